// File: doc/BRIEF.md
# Guarded Configuration Byte over I2C

This block is the serial front end of a supply supervisor. It answers on a two-wire I2C bus and guards one configuration byte that holds the watchdog period, the power-up delay and the block-protect setting. Those five bits live in a modelled nonvolatile cell. They survive reset and drive the rest of the chip through parallel outputs.

The register only answers under its own device-type nibble and at one fixed 9-bit address. A write is refused unless two volatile latches have been armed first. The first write arms the write-enable latch, the second arms the register-write latch, and only the third write reaches the stored fields. A write carries a single data byte and takes effect only at STOP. After a commit the cell is busy for a set number of clocks, and during that time the device does not acknowledge its slave byte. A random read returns the byte together with the two latch bits.

Top module: `cfgbyte_i2c_guard`

## Requirements
- R1: The slave byte is acknowledged only when bits [7:4] equal 1011 and bits [3:2] equal the DEV_SEL parameter (default 00). Bit 1 is the address bit A8 and bit 0 is read (1) or write (0). On any other slave byte the SDA line is left released until the next START.
- R2: In a write, the byte that follows the slave byte is acknowledged only when {A8, byte} equals 9'h1FF. Otherwise it is not acknowledged.
- R3: The first data byte of a write is acknowledged. Every further data byte in the same transaction is not acknowledged.
- R4: When the register-write latch is 0, a STOP after data byte 02h sets the write-enable latch. A STOP after 06h sets the register-write latch, but only if the write-enable latch is already 1. Any other byte leaves both latches and the stored fields unchanged.
- R5: When the register-write latch is 1, a STOP after the data byte commits it. The fields are taken as PUP1=bit7, WD1=bit6, WD0=bit5, BP=bit4 and PUP0=bit0. The commit clears both latches. The outputs are cfg_pup={PUP1,PUP0}, cfg_wd={WD1,WD0} and cfg_bp=BP.
- R6: A write whose data byte is followed by a repeated START instead of a STOP changes neither the latches nor the fields.
- R7: A read (slave-byte bit 0 = 1, A8 = 1) is acknowledged only if the last address byte since reset matched 1FFh. It returns {PUP1, WD1, WD0, BP, 0, RWL, WEL, PUP0}, MSB first, where RWL is the register-write latch and WEL is the write-enable latch.
- R8: A read delivers exactly one byte and then releases SDA, whether the master answers ACK or NACK. It may be closed by a STOP or by a repeated START.
- R9: For BUSY_CYCLES clocks after a commit, every slave byte is not acknowledged.
- R10: Reset clears both latches and the address match, and leaves the stored fields unchanged.
- R11: At power-up the stored fields hold NV_INIT (default all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_out | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_wd | output | 2 | Stored watchdog period {WD1, WD0} |
| cfg_pup | output | 2 | Stored power-up delay {PUP1, PUP0} |
| cfg_bp | output | 1 | Stored block-protect bit |

## Verification
Some rules are checked by the bound checker on every cycle:
- The register-write latch is never set while the write-enable latch is clear.
- The stored fields move only at the start of a busy window, and only when the register-write latch was armed.
- Both latches read 0 after a commit and after reset.
- No slave byte is acknowledged while the cell is busy.

The rest can only be shown by bus scenarios in the bench:
- byte decoding and the acknowledge pattern;
- that a third write is needed before the fields change;
- that a repeated START discards a pending write;
- the one-byte read and its bit layout;
- that the fields survive reset.

// File: rtl/cfgguard_pkg.sv
package cfgguard_pkg;

    localparam logic [3:0] PREAMBLE  = 4'b1011;
    localparam logic [8:0] REG_ADDR  = 9'h1FF;
    localparam logic [7:0] ARM_CODE  = 8'h02;
    localparam logic [7:0] ARM2_CODE = 8'h06;

    typedef struct packed {
        logic pup1;
        logic wd1;
        logic wd0;
        logic bp;
        logic pup0;
    } nv_fields_t;

    typedef enum logic [2:0] {
        L_IDLE, L_RX, L_ACK, L_TX, L_RACK
    } link_state_t;

    typedef enum logic [1:0] {
        K_SLAVE, K_ADDR, K_DATA
    } byte_kind_t;

    function automatic nv_fields_t fields_from_byte(input logic [7:0] b);
        nv_fields_t f;
        f.pup1 = b[7];
        f.wd1  = b[6];
        f.wd0  = b[5];
        f.bp   = b[4];
        f.pup0 = b[0];
        return f;
    endfunction

    function automatic logic [7:0] readback(input nv_fields_t f,
                                            input logic rwl,
                                            input logic wel);
        return {f.pup1, f.wd1, f.wd0, f.bp, 1'b0, rwl, wel, f.pup0};
    endfunction

endpackage

// File: rtl/cfgguard_sync.sv
module cfgguard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_d  <= scl_sr[STAGES-1];
            sda_d  <= sda_sr[STAGES-1];
        end
    end

    assign scl_s     = scl_sr[STAGES-1];
    assign sda_s     = sda_sr[STAGES-1];
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;

endmodule

// File: rtl/cfgguard_link.sv
module cfgguard_link
    import cfgguard_pkg::*;
#(
    parameter logic [1:0] DEV_SEL = 2'b00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_evt,
    input  logic        stop_evt,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        sda_s,
    input  logic        busy,
    input  logic [7:0]  rd_byte,
    output logic        sda_oe,
    output logic        commit_req,
    output logic [7:0]  commit_byte,
    output link_state_t st_o,
    output byte_kind_t  kind_o
);
    link_state_t st;
    byte_kind_t  kind;
    logic [3:0]  bitcnt;
    logic [7:0]  sh;
    logic [7:0]  txsh;
    logic        rw;
    logic        a8;
    logic        ptr_hit;
    logic        got_data;
    logic [7:0]  pend;
    logic        pend_v;

    logic slave_ok;
    logic addr_ok;

    always_comb begin
        slave_ok = (sh[7:4] == PREAMBLE) && (sh[3:2] == DEV_SEL) && !busy &&
                   (!sh[0] || (ptr_hit && sh[1] == REG_ADDR[8]));
        addr_ok  = ({a8, sh} == REG_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= L_IDLE;
            kind       <= K_SLAVE;
            bitcnt     <= '0;
            sh         <= '0;
            txsh       <= '0;
            rw         <= 1'b0;
            a8         <= 1'b0;
            ptr_hit    <= 1'b0;
            got_data   <= 1'b0;
            pend       <= '0;
            pend_v     <= 1'b0;
            commit_req <= 1'b0;
        end else begin
            commit_req <= 1'b0;
            if (stop_evt) begin
                commit_req <= pend_v;
                pend_v     <= 1'b0;
                st         <= L_IDLE;
            end else if (start_evt) begin
                st       <= L_RX;
                kind     <= K_SLAVE;
                bitcnt   <= '0;
                pend_v   <= 1'b0;
                got_data <= 1'b0;
            end else begin
                unique case (st)
                    L_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            sh     <= {sh[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            unique case (kind)
                                K_SLAVE: begin
                                    rw <= sh[0];
                                    a8 <= sh[1];
                                    st <= slave_ok ? L_ACK : L_IDLE;
                                end
                                K_ADDR: begin
                                    ptr_hit <= addr_ok;
                                    st      <= addr_ok ? L_ACK : L_IDLE;
                                end
                                default: begin
                                    if (!got_data) begin
                                        pend     <= sh;
                                        pend_v   <= 1'b1;
                                        got_data <= 1'b1;
                                        st       <= L_ACK;
                                    end else begin
                                        st <= L_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    L_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == K_SLAVE && rw) begin
                                st   <= L_TX;
                                txsh <= rd_byte;
                            end else begin
                                st   <= L_RX;
                                kind <= (kind == K_SLAVE) ? K_ADDR : K_DATA;
                            end
                        end
                    end
                    L_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                st <= L_RACK;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    L_RACK: begin
                        if (scl_rise) st <= L_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe      = (st == L_ACK) || (st == L_TX && !txsh[7]);
    assign commit_byte = pend;
    assign st_o        = st;
    assign kind_o      = kind;

endmodule

// File: rtl/cfgguard_store.sv
module cfgguard_store
    import cfgguard_pkg::*;
#(
    parameter int         BUSY_CYCLES = 500,
    parameter logic [4:0] NV_INIT     = 5'b00000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit_req,
    input  logic [7:0] commit_byte,
    output nv_fields_t nv,
    output logic       wel,
    output logic       rwl,
    output logic       busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    nv_fields_t    nv_q = nv_fields_t'(NV_INIT);
    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (commit_req && rwl && !rst) nv_q <= fields_from_byte(commit_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel      <= 1'b0;
            rwl      <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (commit_req) begin
                if (rwl) begin
                    wel      <= 1'b0;
                    rwl      <= 1'b0;
                    busy_cnt <= CW'(BUSY_CYCLES);
                end else if (commit_byte == ARM_CODE) begin
                    wel <= 1'b1;
                end else if (commit_byte == ARM2_CODE && wel) begin
                    rwl <= 1'b1;
                end
            end
        end
    end

    assign nv   = nv_q;
    assign busy = (busy_cnt != '0);

endmodule

// File: rtl/cfgbyte_i2c_guard.sv
module cfgbyte_i2c_guard
    import cfgguard_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] DEV_SEL     = 2'b00,
    parameter int         BUSY_CYCLES = 500,
    parameter logic [4:0] NV_INIT     = 5'b00000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_out,
    output logic       sda_oe,
    output logic [1:0] cfg_wd,
    output logic [1:0] cfg_pup,
    output logic       cfg_bp
);
    logic        sda_s, start_evt, stop_evt, scl_rise, scl_fall;
    logic        busy, wel, rwl, commit_req;
    logic [7:0]  commit_byte;
    nv_fields_t  nv;
    link_state_t link_st;
    byte_kind_t  link_kind;

    cfgguard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    cfgguard_link #(.DEV_SEL(DEV_SEL)) u_link (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .busy(busy), .rd_byte(readback(nv, rwl, wel)),
        .sda_oe(sda_oe), .commit_req(commit_req), .commit_byte(commit_byte),
        .st_o(link_st), .kind_o(link_kind)
    );

    cfgguard_store #(.BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)) u_store (
        .clk(clk), .rst(rst), .commit_req(commit_req),
        .commit_byte(commit_byte), .nv(nv), .wel(wel), .rwl(rwl), .busy(busy)
    );

    assign sda_out = 1'b0;
    assign cfg_wd  = {nv.wd1, nv.wd0};
    assign cfg_pup = {nv.pup1, nv.pup0};
    assign cfg_bp  = nv.bp;

endmodule

// File: rtl/cfgguard_chk.sv
module cfgguard_chk
    import cfgguard_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wel,
    input logic        rwl,
    input logic        busy,
    input nv_fields_t  nv,
    input link_state_t link_st,
    input byte_kind_t  link_kind
);
    assert_rwl_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
        rwl |-> wel);

    assert_commit_armed_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(rwl) && !wel && !rwl));

    assert_fields_move_on_commit_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv) |-> $rose(busy));

    assert_no_slave_ack_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (link_st == L_ACK && link_kind == K_SLAVE) |-> !busy);

    assert_reset_clears_latches_R10: assert property (@(posedge clk)
        rst |=> (!wel && !rwl));

endmodule

bind cfgbyte_i2c_guard cfgguard_chk chk_i (
    .clk(clk), .rst(rst), .wel(wel), .rwl(rwl), .busy(busy), .nv(nv),
    .link_st(link_st), .link_kind(link_kind)
);

// File: tb/cfgbyte_i2c_guard_tb.sv
module cfgbyte_i2c_guard_tb_top;

    localparam int Q    = 8;
    localparam int BUSY = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_oe = 1'b0;
    logic sda_out, sda_oe, cfg_bp;
    logic [1:0] cfg_wd, cfg_pup;
    logic sda_line;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign sda_line = !(m_oe || sda_oe);

    cfgbyte_i2c_guard #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .sda_out(sda_out), .sda_oe(sda_oe),
        .cfg_wd(cfg_wd), .cfg_pup(cfg_pup), .cfg_bp(cfg_bp)
    );

    // {data byte written, expected readback afterwards}
    localparam logic [15:0] VEC [12] = '{
        16'hF1_00, 16'h06_00, 16'h02_02, 16'h06_06,
        16'hA1_A1, 16'h5E_A1, 16'h02_A3, 16'h06_A7,
        16'hFF_F1, 16'h02_F3, 16'h06_F7, 16'h50_50
    };

    task automatic wait_q(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_oe = 1'b0; wait_q(Q);
        scl  = 1'b1; wait_q(Q);
        m_oe = 1'b1; wait_q(Q);
        scl  = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_oe = 1'b1; wait_q(Q);
        scl  = 1'b1; wait_q(Q);
        m_oe = 1'b0; wait_q(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_oe = ~b[i]; wait_q(Q);
            scl  = 1'b1;  wait_q(2*Q);
            scl  = 1'b0;  wait_q(Q);
        end
        m_oe = 1'b0; wait_q(Q);
        scl  = 1'b1; wait_q(Q);
        @(negedge clk);
        ack = !sda_line;
        wait_q(Q);
        scl = 1'b0; wait_q(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        m_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q(Q);
            scl = 1'b1; wait_q(Q);
            @(negedge clk);
            b[i] = sda_line;
            wait_q(Q);
            scl = 1'b0;
        end
        wait_q(Q);
        m_oe = m_ack; wait_q(Q);
        scl  = 1'b1;  wait_q(2*Q);
        scl  = 1'b0;  wait_q(Q);
        m_oe = 1'b0;
    endtask

    task automatic wr_txn(input logic [7:0] d, output logic a_data);
        logic a;
        bus_start();
        send_byte(8'hB2, a); chk("R1 slave ack", {7'd0, a}, 8'd1);
        send_byte(8'hFF, a); chk("R2 addr ack", {7'd0, a}, 8'd1);
        send_byte(d, a_data);
        bus_stop();
    endtask

    task automatic rd_txn(output logic [7:0] v);
        logic a;
        bus_start();
        send_byte(8'hB2, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(8'hB3, a); chk("R7 read slave ack", {7'd0, a}, 8'd1);
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    function automatic logic [7:0] out_byte();
        return {cfg_pup[1], cfg_wd, cfg_bp, 3'b000, cfg_pup[0]};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic a, a2;
        wait_q(5);
        rst = 1'b0;
        wait_q(5);

        // R11: power-up fields and reset state
        chk("R11 outputs at power-up", out_byte(), 8'h00);
        rd_txn(v); chk("R11 readback at power-up", v, 8'h00);

        // table of writes: arming sequence and commits (R4, R5, R7)
        for (int k = 0; k < 12; k++) begin
            wr_txn(VEC[k][15:8], a);
            chk("R3 first data byte ack", {7'd0, a}, 8'd1);
            wait_q(BUSY + 100);
            rd_txn(v);
            chk("R4 R5 R7 readback after write", v, VEC[k][7:0]);
            chk("R5 field outputs", out_byte(), VEC[k][7:0] & 8'hF1);
        end

        // R1: wrong preamble and wrong device select
        bus_start(); send_byte(8'hA2, a); bus_stop();
        chk("R1 wrong preamble nack", {7'd0, a}, 8'd0);
        bus_start(); send_byte(8'hB6, a); bus_stop();
        chk("R1 wrong device select nack", {7'd0, a}, 8'd0);

        // R2: address mismatch
        bus_start(); send_byte(8'hB0, a); send_byte(8'hFF, a2); bus_stop();
        chk("R2 A8 clear nack", {7'd0, a2}, 8'd0);
        bus_start(); send_byte(8'hB2, a); send_byte(8'hFE, a2); bus_stop();
        chk("R2 low address mismatch nack", {7'd0, a2}, 8'd0);

        // R3: second data byte refused; only the first takes effect
        bus_start(); send_byte(8'hB2, a); send_byte(8'hFF, a);
        send_byte(8'h02, a); send_byte(8'h06, a2); bus_stop();
        chk("R3 first byte ack", {7'd0, a}, 8'd1);
        chk("R3 second byte nack", {7'd0, a2}, 8'd0);
        rd_txn(v); chk("R3 only first byte applied", v, 8'h52);

        // R6: repeated START instead of STOP discards the write
        bus_start(); send_byte(8'hB2, a); send_byte(8'hFF, a);
        send_byte(8'h06, a);
        bus_start(); send_byte(8'hB3, a); recv_byte(v, 1'b0); bus_stop();
        chk("R6 no latch change on restart", v, 8'h52);
        rd_txn(v); chk("R6 readback after restart", v, 8'h52);

        // R8: master ACK ends the read too; read closed by repeated START
        bus_start(); send_byte(8'hB2, a); send_byte(8'hFF, a);
        bus_start(); send_byte(8'hB3, a); recv_byte(v, 1'b1);
        chk("R8 read with master ack", v, 8'h52);
        bus_start(); send_byte(8'hB3, a); recv_byte(v, 1'b0); bus_stop();
        chk("R8 read after repeated start ack", {7'd0, a}, 8'd1);
        chk("R8 read after repeated start value", v, 8'h52);

        // R9: busy window refuses the slave byte
        wr_txn(8'h06, a);
        wr_txn(8'h30, a);
        bus_start(); send_byte(8'hB2, a); bus_stop();
        chk("R9 nack while busy", {7'd0, a}, 8'd0);
        wait_q(BUSY + 100);
        rd_txn(v); chk("R9 commit after busy", v, 8'h30);
        chk("R5 outputs after commit", {4'd0, cfg_wd, cfg_pup}, 8'h04);
        chk("R5 bp output", {7'd0, cfg_bp}, 8'd1);

        // R10: reset clears latches and address match, keeps fields
        wr_txn(8'h02, a);
        rd_txn(v); chk("R4 WEL armed", v, 8'h32);
        rst = 1'b1; wait_q(4); rst = 1'b0; wait_q(4);
        chk("R10 fields kept over reset", out_byte(), 8'h30);
        bus_start(); send_byte(8'hB3, a); bus_stop();
        chk("R10 address match cleared", {7'd0, a}, 8'd0);
        rd_txn(v); chk("R10 latches cleared", v, 8'h30);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule